// File: doc/BRIEF.md
# Token-Sequenced Column Data Loader

This block fills a row of gray-level column slots for a cascadeable display column driver. A single marker bit, the token, is taken in from a serial token input and then walks one slot per enabled load cycle along the chain of slots. On each enabled cycle, the slot that holds the token takes the 6-bit value on the data bus into its temporary storage. When the final slot of the chain has loaded, the token leaves the device on the token output. That output feeds the token input of the next device in a cascade.

The walk can run in either direction. By default the token enters at slot 0, the rightmost column, and climbs toward the left. When reversed, it enters at the highest active slot and descends. A mode select shortens the chain from 200 slots to 192. A separate latch strobe copies the whole temporary row into the output register, which drives the pulse generator. The output register holds its value until the next strobe.

Top module: `tkl_loader`

## Requirements
- R1: After synchronous reset the output register is all zero, `tok_out` is 0 and no slot holds the token.
- R2: `tok_in` is taken only on a clock edge where `load_en` is 1 and no slot holds the token. It places the token at the entry slot, and no slot captures data on that edge. With `load_en` at 0, `tok_in` has no effect.
- R3: On each edge where `load_en` is 1, the slot holding the token captures `data_in` and the token moves one slot onward. On edges where `load_en` is 0, nothing is captured and the token stays where it is.
- R4: With `rev_dir` = 0, the token enters at slot 0 and visits slots in ascending order. Slot k appears in `out_data[6k+5:6k]`.
- R5: With `rev_dir` = 1, the token enters at the highest active slot (199, or 191 in short mode) and visits slots in descending order down to slot 0.
- R6: `tok_out` is 1 for exactly one clock cycle, following the enabled edge on which the final slot of the walk captured. The token is then gone, and a further enabled cycle captures nothing.
- R7: While any slot holds the token, `tok_in` is ignored, so at most one token exists at a time.
- R8: An edge with `latch` at 1 copies every active slot's temporary value into `out_data`. Without `latch`, `out_data` holds. A latch neither moves the token nor changes the temporary values.
- R9: With `short_mode` = 1, only slots 0 to 191 are active. Slots 192 to 199 never capture, and a latch sets their output fields to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tok_in | input | 1 | Serial token input from the previous device |
| load_en | input | 1 | Load enable; advances the token and captures data |
| data_in | input | 6 | Gray-level data for the slot holding the token |
| latch | input | 1 | Copies the temporary row into the output register |
| rev_dir | input | 1 | 0: ascending walk from slot 0; 1: descending walk from the top active slot |
| short_mode | input | 1 | 1: chain of 192 slots; 0: chain of 200 slots |
| tok_out | output | 1 | Token passed on to the next cascaded device |
| out_data | output | 1200 | Output register, slot k at bits [6k+5:6k] |

## Verification
The assertions assume that `rev_dir` and `short_mode` stay fixed while a token is inside the chain. A mode or direction change in the middle of a walk could strand or drop the token, and the one-shot token-output properties would no longer describe a legal fill. The bench changes these selects only between fills, once the token has left and `tok_out` has returned low. It also keeps `latch` and `load_en` apart, so that each strobe observes a settled row.

// File: rtl/tkl_pkg.sv
package tkl_pkg;

    localparam int unsigned GRAY_W      = 6;
    localparam int unsigned FULL_SLOTS  = 200;
    localparam int unsigned SHORT_SLOTS = 192;

    // Direction of the token walk along the slot chain.
    typedef enum logic {
        WALK_UP   = 1'b0,
        WALK_DOWN = 1'b1
    } walk_e;

    // Number of slots taking part in a walk for the selected mode.
    function automatic logic [31:0] live_count(input logic short_sel,
                                               input logic [31:0] full_n,
                                               input logic [31:0] short_n);
        return short_sel ? short_n : full_n;
    endfunction

endpackage

// File: rtl/tkl_token_chain.sv
module tkl_token_chain
    import tkl_pkg::*;
#(
    parameter int unsigned N       = FULL_SLOTS,
    parameter int unsigned SHORT_N = SHORT_SLOTS
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load_en,
    input  logic         tok_in,
    input  walk_e        dir,
    input  logic         short_mode,
    output logic [N-1:0] tok_q,
    output logic [N-1:0] active,
    output logic         tok_out
);
    localparam int unsigned IDX_W = (N > 1) ? $clog2(N) : 1;

    logic [31:0]      live_n;
    logic [IDX_W-1:0] last_idx;
    logic [IDX_W-1:0] entry_idx;
    logic [N-1:0]     tok_nxt;
    logic             inject;
    logic             leave;

    always_comb begin
        live_n    = live_count(short_mode, 32'(N), 32'(SHORT_N));
        last_idx  = IDX_W'(live_n - 32'd1);
        entry_idx = (dir == WALK_DOWN) ? last_idx : '0;
        inject    = tok_in & ~(|tok_q);
        leave     = (dir == WALK_DOWN) ? tok_q[0] : tok_q[last_idx];
    end

    for (genvar i = 0; i < N; i++) begin : g_slot
        logic from_lo;
        logic from_hi;
        if (i > 0) begin : g_lo
            assign from_lo = tok_q[i-1];
        end else begin : g_lo0
            assign from_lo = 1'b0;
        end
        if (i < N - 1) begin : g_hi
            assign from_hi = tok_q[i+1];
        end else begin : g_hiN
            assign from_hi = 1'b0;
        end
        assign active[i]  = (32'(i) < live_n);
        assign tok_nxt[i] = (active[i] & ((dir == WALK_DOWN) ? from_hi : from_lo))
                          | (inject & (entry_idx == IDX_W'(i)));
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tok_q   <= '0;
            tok_out <= 1'b0;
        end else begin
            tok_out <= load_en & leave;
            if (load_en) begin
                tok_q <= tok_nxt;
            end
        end
    end

endmodule

// File: rtl/tkl_slot_bank.sv
module tkl_slot_bank
    import tkl_pkg::*;
#(
    parameter int unsigned N = FULL_SLOTS,
    parameter int unsigned W = GRAY_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic [N-1:0]   capture,
    input  logic [N-1:0]   active,
    input  logic [W-1:0]   data_in,
    input  logic           latch,
    output logic [N*W-1:0] out_data
);
    logic [W-1:0] tmp_q [N];
    logic [W-1:0] out_q [N];

    for (genvar i = 0; i < N; i++) begin : g_cell
        always_ff @(posedge clk) begin
            if (rst) begin
                tmp_q[i] <= '0;
                out_q[i] <= '0;
            end else begin
                if (capture[i]) begin
                    tmp_q[i] <= data_in;
                end
                if (latch) begin
                    out_q[i] <= active[i] ? tmp_q[i] : '0;
                end
            end
        end
        assign out_data[i*W +: W] = out_q[i];
    end

endmodule

// File: rtl/tkl_loader.sv
module tkl_loader
    import tkl_pkg::*;
#(
    parameter int unsigned NUM_SLOTS   = FULL_SLOTS,
    parameter int unsigned SHORT_SLOTS = tkl_pkg::SHORT_SLOTS,
    parameter int unsigned DATA_W      = GRAY_W
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        tok_in,
    input  logic                        load_en,
    input  logic [DATA_W-1:0]           data_in,
    input  logic                        latch,
    input  logic                        rev_dir,
    input  logic                        short_mode,
    output logic                        tok_out,
    output logic [NUM_SLOTS*DATA_W-1:0] out_data
);
    logic [NUM_SLOTS-1:0] tok_q;
    logic [NUM_SLOTS-1:0] active;
    logic [NUM_SLOTS-1:0] capture;
    walk_e                dir;

    assign dir     = walk_e'(rev_dir);
    assign capture = load_en ? (tok_q & active) : '0;

    tkl_token_chain #(
        .N       (NUM_SLOTS),
        .SHORT_N (SHORT_SLOTS)
    ) u_chain (
        .clk        (clk),
        .rst        (rst),
        .load_en    (load_en),
        .tok_in     (tok_in),
        .dir        (dir),
        .short_mode (short_mode),
        .tok_q      (tok_q),
        .active     (active),
        .tok_out    (tok_out)
    );

    tkl_slot_bank #(
        .N (NUM_SLOTS),
        .W (DATA_W)
    ) u_bank (
        .clk      (clk),
        .rst      (rst),
        .capture  (capture),
        .active   (active),
        .data_in  (data_in),
        .latch    (latch),
        .out_data (out_data)
    );

endmodule

// File: rtl/tkl_loader_chk.sv
module tkl_loader_chk #(
    parameter int unsigned N       = 200,
    parameter int unsigned SHORT_N = 192,
    parameter int unsigned W       = 6
) (
    input logic           clk,
    input logic           rst,
    input logic           load_en,
    input logic           latch,
    input logic           short_mode,
    input logic           tok_out,
    input logic [N-1:0]   tok_q,
    input logic [N*W-1:0] out_data
);
    // R7
    single_token_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(tok_q));

    // R3
    token_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !load_en |=> $stable(tok_q));

    // R8
    out_hold_chk: assert property (@(posedge clk) disable iff (rst)
        !latch |=> $stable(out_data));

    // R6
    tok_out_cause_chk: assert property (@(posedge clk) disable iff (rst)
        tok_out |-> $past(load_en));

    // R6
    tok_out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tok_out |=> !tok_out);

    if (SHORT_N < N) begin : g_short
        // R9
        short_upper_zero_chk: assert property (@(posedge clk) disable iff (rst)
            (latch && short_mode) |=> (out_data[N*W-1:SHORT_N*W] == '0));
    end

endmodule

bind tkl_loader tkl_loader_chk #(
    .N       (NUM_SLOTS),
    .SHORT_N (SHORT_SLOTS),
    .W       (DATA_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .load_en    (load_en),
    .latch      (latch),
    .short_mode (short_mode),
    .tok_out    (tok_out),
    .tok_q      (tok_q),
    .out_data   (out_data)
);

// File: tb/sim_tkl_loader.sv
module sim_tkl_loader;
    localparam int N = 200;
    localparam int S = 192;
    localparam int W = 6;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           tok_in = 1'b0;
    logic           load_en = 1'b0;
    logic [W-1:0]   data_in = '0;
    logic           latch = 1'b0;
    logic           rev_dir = 1'b0;
    logic           short_mode = 1'b0;
    logic           tok_out;
    logic [N*W-1:0] out_data;

    int checks = 0;
    int errors = 0;
    logic [W-1:0] exp_tmp [N];
    logic [W-1:0] exp_out [N];

    always #10 clk = ~clk;

    tkl_loader u0 (
        .clk(clk), .rst(rst), .tok_in(tok_in), .load_en(load_en),
        .data_in(data_in), .latch(latch), .rev_dir(rev_dir),
        .short_mode(short_mode), .tok_out(tok_out), .out_data(out_data)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic drive(input logic le, input logic ti, input logic [W-1:0] d,
                         input logic lt);
        @(negedge clk);
        load_en = le; tok_in = ti; data_in = d; latch = lt;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [W-1:0] gray(input int slot, input int seed);
        return W'((slot * 5 + seed * 11 + 1) % 64);
    endfunction

    task automatic check_out(input string req, input string what);
        int bad = 0;
        int first = -1;
        for (int s = 0; s < N; s++) begin
            if (out_data[s*W +: W] !== exp_out[s]) begin
                bad++;
                if (first < 0) first = s;
            end
        end
        if (first >= 0)
            $display("  first differing slot %0d: got %0d want %0d", first,
                     out_data[first*W +: W], exp_out[first]);
        chk(bad == 0, req, what, bad, 0);
    endtask

    task automatic do_latch(input bit short_sel, input string req);
        drive(1'b0, 1'b0, '0, 1'b1);
        for (int s = 0; s < N; s++)
            exp_out[s] = (!short_sel || s < S) ? exp_tmp[s] : '0;
        check_out(req, "row after latch");
    endtask

    // One complete walk: optional stalls, tok_in held high while busy,
    // optional latch partway through the walk.
    task automatic fill(input bit rev, input bit short_sel, input int gap,
                        input int seed, input int mid_latch, input string req);
        int cnt = short_sel ? S : N;
        drive(1'b0, 1'b0, '0, 1'b0);
        rev_dir = rev;
        short_mode = short_sel;
        // R2: tok_in without load_en does nothing; an enabled cycle with no token captures nothing
        drive(1'b0, 1'b1, 6'd63, 1'b0);
        drive(1'b1, 1'b0, 6'd63, 1'b0);
        chk(tok_out === 1'b0, "R2", "tok_out with empty chain", tok_out, 0);
        // inject (no capture on this edge)
        drive(1'b1, 1'b1, 6'd62, 1'b0);
        for (int k = 0; k < cnt; k++) begin
            int slot = rev ? (cnt - 1 - k) : k;
            if (gap > 0 && (k % gap) == 0)
                drive(1'b0, 1'b1, 6'd61, 1'b0);
            if (k == mid_latch) begin
                do_latch(short_sel, "R8");
            end
            // R7: tok_in held high while the token is in the chain
            drive(1'b1, 1'b1, gray(slot, seed), 1'b0);
            exp_tmp[slot] = gray(slot, seed);
            if (k == cnt - 2)
                chk(tok_out === 1'b0, "R6", "tok_out before final slot", tok_out, 0);
            if (k == cnt - 1)
                chk(tok_out === 1'b1, "R6", "tok_out after final slot", tok_out, 1);
        end
        // token gone: an enabled cycle must capture nothing
        drive(1'b1, 1'b0, 6'd60, 1'b0);
        chk(tok_out === 1'b0, "R6", "tok_out one cycle only", tok_out, 0);
        check_out("R8", "row held without latch");
        do_latch(short_sel, req);
    endtask

    task automatic t_reset();
        for (int s = 0; s < N; s++) begin
            exp_tmp[s] = '0;
            exp_out[s] = '0;
        end
        chk(tok_out === 1'b0, "R1", "tok_out after reset", tok_out, 0);
        check_out("R1", "row after reset");
        do_latch(1'b0, "R1");
    endtask

    task automatic t_forward();    fill(1'b0, 1'b0, 0, 1, -1, "R4"); endtask
    task automatic t_reverse();    fill(1'b1, 1'b0, 7, 2, -1, "R5"); endtask
    task automatic t_stall_fwd();  fill(1'b0, 1'b0, 3, 5, -1, "R3"); endtask
    task automatic t_short_fwd();  fill(1'b0, 1'b1, 0, 3, -1, "R9"); endtask
    task automatic t_short_rev();  fill(1'b1, 1'b1, 5, 4, -1, "R9"); endtask
    task automatic t_mid_latch();  fill(1'b0, 1'b0, 0, 6, 90, "R7"); endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(posedge clk);
        #1;
        t_reset();
        t_forward();
        t_reverse();
        t_stall_fwd();
        t_short_fwd();
        t_short_rev();
        t_mid_latch();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule